// File: doc/BRIEF.md
# ECC Diagnostic Error Injector

This block sits on the read-return path of a memory whose words carry 64 data bits and an 8-bit SECDED check byte. Each read response arrives with a tag that gives its origin: a direct processor fetch or a slave-port (DMA-style) transfer. Software first programs a small register set: a diagnostic mode field, two independent unlock keys and an 8-bit inversion mask. When all three control values hold their arming codes, every slave-tagged response leaves the block with its check byte XORed with the mask. Direct processor responses and all responses while the block is disarmed pass through unchanged.

A built-in SECDED checker decodes every outgoing response. It raises a single-error or a double-error flag and supplies a corrected data word. A self-test can then confirm that a chosen mask is seen as the intended fault class. For a single data-bit fault, the test can also confirm which bit the checker located. The response path is one register stage, controlled by a two-state machine. The state is IDLE when no response is held and RESP while a registered response is presented. A valid input moves either state to RESP. A cycle without a valid input moves either state to IDLE.

Top module: `ecc_diag_injector`

## Requirements
- R1: After reset, the mode field, both keys and the mask are zero, and `rsp_valid`, `rsp_sbe` and `rsp_dbe` are low.
- R2: Configuration writes use `cfg_sel` to pick the target. Code 0 is the mode (`cfg_wdata[2:0]`), 1 is the override key (`[3:0]`), 2 is the enable key (`[3:0]`) and 3 is the mask (`[7:0]`). Injection is armed only while the mode is 7 and both keys are 5.
- R3: When armed and `rd_dma`=1, `rsp_check` equals `rd_check` XOR mask, and `rsp_data` equals `rd_data`.
- R4: Responses with `rd_dma`=0 are never altered, even when the block is armed.
- R5: Changing any key away from 5, or the mode away from 7, disarms the block starting with the next read. The mask keeps its value, and re-arming brings the same corruption back.
- R6: The check byte is the XOR of the H columns of all set data bits. Column 0 is 0xCE and column 62 is 0x70. The other columns, for bits 1..61 and then 63, are taken in ascending order from the 8-bit values of weight 3 or 5, leaving out 0x70 and 0xCE.
- R7: A zero syndrome (received check XOR recomputed check) raises no flag, and `rsp_corr_data` equals `rsp_data`.
- R8: A syndrome equal to a data column raises `rsp_sbe` only, and `rsp_corr_data` has that bit flipped. Mask 0x70 locates bit 62 and mask 0xCE locates bit 0.
- R9: A mask with exactly one bit set raises `rsp_sbe` only, with `rsp_corr_data` equal to the data. A mask with exactly two bits set raises `rsp_dbe` only.
- R10: Responses appear exactly one clock after `rd_valid`. `rsp_valid` is low in any cycle after a clock with no input, and the flags are low whenever `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration target select |
| cfg_wdata | input | 8 | Configuration write data |
| rd_valid | input | 1 | Read response valid |
| rd_dma | input | 1 | 1 = slave/DMA origin, 0 = direct processor |
| rd_data | input | 64 | Read data word |
| rd_check | input | 8 | Stored check byte |
| rsp_valid | output | 1 | Registered response valid |
| rsp_data | output | 64 | Data word, unmodified |
| rsp_check | output | 8 | Check byte, possibly corrupted |
| rsp_corr_data | output | 64 | Data after single-bit correction |
| rsp_sbe | output | 1 | Single error detected |
| rsp_dbe | output | 1 | Double (uncorrectable) error detected |

## Verification
Every response output, including the flags and the corrected word, belongs to the clock edge after the one that sampled `rd_valid`. The bench drives a read on a falling edge, removes it on the next falling edge and samples there, which is one rising edge after capture. A configuration write becomes effective at the rising edge that follows its falling-edge drive, so every read is issued at least one full cycle after the write it depends on. The idle check samples one further falling edge later, after a rising edge that saw no valid input.

// File: rtl/ecc_diag_pkg.sv
package ecc_diag_pkg;
    localparam int DATA_W = 64;
    localparam int CHK_W  = 8;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rsp_state_e;

    typedef enum logic [1:0] {
        SEL_MODE = 2'd0,
        SEL_OKEY = 2'd1,
        SEL_EKEY = 2'd2,
        SEL_MASK = 2'd3
    } cfg_sel_e;

    // Distinct odd-weight columns; bit 0 and bit 62 are pinned.
    function automatic logic [DATA_W-1:0][CHK_W-1:0] build_cols();
        logic [DATA_W-1:0][CHK_W-1:0] c;
        int k;
        c = '0;
        k = 1;
        for (int v = 0; v < 256; v++) begin
            logic [7:0] vb;
            int w;
            vb = v[7:0];
            w  = $countones(vb);
            if ((w == 3 || w == 5) && vb != 8'h70 && vb != 8'hCE) begin
                if (k == 62) k = 63;
                if (k < DATA_W) begin
                    c[k] = vb;
                    k++;
                end
            end
        end
        c[0]  = 8'hCE;
        c[62] = 8'h70;
        return c;
    endfunction

    localparam logic [DATA_W-1:0][CHK_W-1:0] H_COLS = build_cols();
endpackage

// File: rtl/ecc_diag_cfg.sv
module ecc_diag_cfg
    import ecc_diag_pkg::*;
#(
    parameter int MODE_W   = 3,
    parameter int KEY_W    = 4,
    parameter int ARM_MODE = 7,
    parameter int ARM_KEY  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [7:0]       cfg_wdata,
    output logic [CHK_W-1:0] inv_mask,
    output logic             armed
);
    logic [MODE_W-1:0] mode_q;
    logic [KEY_W-1:0]  okey_q;
    logic [KEY_W-1:0]  ekey_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            okey_q   <= '0;
            ekey_q   <= '0;
            inv_mask <= '0;
        end else if (cfg_we) begin
            unique case (cfg_sel_e'(cfg_sel))
                SEL_MODE: mode_q   <= cfg_wdata[MODE_W-1:0];
                SEL_OKEY: okey_q   <= cfg_wdata[KEY_W-1:0];
                SEL_EKEY: ekey_q   <= cfg_wdata[KEY_W-1:0];
                SEL_MASK: inv_mask <= cfg_wdata[CHK_W-1:0];
            endcase
        end
    end

    always_comb begin
        armed = (mode_q == MODE_W'(ARM_MODE)) &&
                (okey_q == KEY_W'(ARM_KEY)) &&
                (ekey_q == KEY_W'(ARM_KEY));
    end
endmodule

// File: rtl/ecc_diag_decode.sv
module ecc_diag_decode
    import ecc_diag_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  logic [CHK_W-1:0]  check,
    output logic              sbe,
    output logic              dbe,
    output logic [DATA_W-1:0] corr_data
);
    logic [CHK_W-1:0]  syndrome;
    logic [DATA_W-1:0] col_hit;
    logic              unit_hit;

    always_comb begin
        syndrome = check;
        for (int i = 0; i < DATA_W; i++) begin
            if (data[i]) syndrome = syndrome ^ H_COLS[i];
        end
    end

    for (genvar g = 0; g < DATA_W; g++) begin : g_col
        assign col_hit[g] = (syndrome == H_COLS[g]);
    end

    always_comb begin
        unit_hit  = ($countones(syndrome) == 1);
        sbe       = unit_hit || (|col_hit);
        dbe       = (syndrome != '0) && !sbe;
        corr_data = data ^ col_hit;
    end
endmodule

// File: rtl/ecc_diag_injector.sv
module ecc_diag_injector
    import ecc_diag_pkg::*;
#(
    parameter int MODE_W   = 3,
    parameter int KEY_W    = 4,
    parameter int ARM_MODE = 7,
    parameter int ARM_KEY  = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [7:0]  cfg_wdata,
    input  logic        rd_valid,
    input  logic        rd_dma,
    input  logic [63:0] rd_data,
    input  logic [7:0]  rd_check,
    output logic        rsp_valid,
    output logic [63:0] rsp_data,
    output logic [7:0]  rsp_check,
    output logic [63:0] rsp_corr_data,
    output logic        rsp_sbe,
    output logic        rsp_dbe
);
    logic [CHK_W-1:0]  inv_mask;
    logic              armed;
    logic [CHK_W-1:0]  chk_mod;
    logic              dec_sbe, dec_dbe;
    logic [DATA_W-1:0] dec_corr;
    rsp_state_e        state_q, state_d;

    ecc_diag_cfg #(
        .MODE_W(MODE_W), .KEY_W(KEY_W), .ARM_MODE(ARM_MODE), .ARM_KEY(ARM_KEY)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .inv_mask(inv_mask), .armed(armed)
    );

    always_comb begin
        chk_mod = (armed && rd_dma) ? (rd_check ^ inv_mask) : rd_check;
    end

    ecc_diag_decode u_dec (
        .data(rd_data), .check(chk_mod),
        .sbe(dec_sbe), .dbe(dec_dbe), .corr_data(dec_corr)
    );

    // Next-state logic for the response stage.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = rd_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_valid ? ST_RESP : ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_data      <= '0;
            rsp_check     <= '0;
            rsp_corr_data <= '0;
            rsp_sbe       <= 1'b0;
            rsp_dbe       <= 1'b0;
        end else if (rd_valid) begin
            rsp_data      <= rd_data;
            rsp_check     <= chk_mod;
            rsp_corr_data <= dec_corr;
            rsp_sbe       <= dec_sbe;
            rsp_dbe       <= dec_dbe;
        end else begin
            rsp_sbe       <= 1'b0;
            rsp_dbe       <= 1'b0;
        end
    end

    always_comb begin
        rsp_valid = (state_q == ST_RESP);
    end
endmodule

// File: rtl/ecc_diag_sva.sv
module ecc_diag_sva (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_valid,
    input logic        rd_dma,
    input logic [63:0] rd_data,
    input logic [7:0]  rd_check,
    input logic        armed,
    input logic        rsp_valid,
    input logic [63:0] rsp_data,
    input logic [7:0]  rsp_check,
    input logic        rsp_sbe,
    input logic        rsp_dbe
);
    logic seen_edge;
    always_ff @(posedge clk) begin
        if (!rst_n) seen_edge <= 1'b0;
        else        seen_edge <= 1'b1;
    end

    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        seen_edge |-> (rsp_valid == $past(rd_valid)));

    a_r3_data_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_edge && rsp_valid) |-> (rsp_data == $past(rd_data)));

    a_r4_cpu_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_edge && rsp_valid && !$past(rd_dma)) |-> (rsp_check == $past(rd_check)));

    a_r5_disarmed_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_edge && rsp_valid && !$past(armed)) |-> (rsp_check == $past(rd_check)));

    a_r10_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_sbe && !rsp_dbe));

    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_sbe && rsp_dbe));
endmodule

bind ecc_diag_injector ecc_diag_sva u_sva (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_dma(rd_dma),
    .rd_data(rd_data), .rd_check(rd_check), .armed(armed),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_check(rsp_check),
    .rsp_sbe(rsp_sbe), .rsp_dbe(rsp_dbe)
);

// File: tb/sim_ecc_diag_injector.sv
`timescale 1ns/1ps
module sim_ecc_diag_injector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        rd_valid = 1'b0;
    logic        rd_dma = 1'b0;
    logic [63:0] rd_data = '0;
    logic [7:0]  rd_check = '0;
    logic        rsp_valid, rsp_sbe, rsp_dbe;
    logic [63:0] rsp_data, rsp_corr_data;
    logic [7:0]  rsp_check;

    int n_checks = 0;
    int n_fail = 0;
    logic [63:0][7:0] cols;

    always #2.5 clk = ~clk;

    ecc_diag_injector u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .rd_valid(rd_valid), .rd_dma(rd_dma),
        .rd_data(rd_data), .rd_check(rd_check), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rsp_check(rsp_check), .rsp_corr_data(rsp_corr_data),
        .rsp_sbe(rsp_sbe), .rsp_dbe(rsp_dbe)
    );

    typedef struct packed {
        logic        dma;
        logic [7:0]  mask;
        logic [63:0] data;
        logic        sbe;
        logic        dbe;
        logic [6:0]  flip;   // 127 = no data bit flipped
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h70, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b0, 7'd62},
        '{1'b1, 8'hCE, 64'hFEDC_BA98_7654_3210, 1'b1, 1'b0, 7'd0},
        '{1'b1, 8'h01, 64'hA5A5_5A5A_0F0F_F0F0, 1'b1, 1'b0, 7'd127},
        '{1'b1, 8'h80, 64'h0000_0000_0000_0000, 1'b1, 1'b0, 7'd127},
        '{1'b1, 8'h03, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1, 7'd127},
        '{1'b1, 8'h90, 64'h1357_9BDF_2468_ACE0, 1'b0, 1'b1, 7'd127},
        '{1'b0, 8'h70, 64'hDEAD_BEEF_CAFE_F00D, 1'b0, 1'b0, 7'd127},
        '{1'b1, 8'h00, 64'h8000_0000_0000_0001, 1'b0, 1'b0, 7'd127}
    };

    // Columns per R6.
    task automatic make_cols();
        int k = 1;
        cols = '0;
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b = v[7:0];
            int w = $countones(b);
            if ((w == 3 || w == 5) && b != 8'h70 && b != 8'hCE) begin
                if (k == 62) k = 63;
                if (k < 64) begin cols[k] = b; k++; end
            end
        end
        cols[0] = 8'hCE;
        cols[62] = 8'h70;
    endtask

    function automatic logic [7:0] good_check(logic [63:0] d);
        logic [7:0] c = '0;
        for (int i = 0; i < 64; i++) if (d[i]) c ^= cols[i];
        return c;
    endfunction

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cfg_write(logic [1:0] sel, logic [7:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drive one read; returns at the falling edge one rising edge later.
    task automatic do_read(logic dma, logic [63:0] d, logic [7:0] c);
        @(negedge clk);
        rd_valid = 1'b1; rd_dma = dma; rd_data = d; rd_check = c;
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    task automatic expect_clean(string req, logic [63:0] d);
        check(req, {63'd0, rsp_valid}, 64'd1);
        check(req, rsp_check, {56'd0, good_check(d)});
        check(req, {62'd0, rsp_sbe, rsp_dbe}, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] d;
        logic [7:0]  gc;
        make_cols();
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", {63'd0, rsp_valid}, 64'd0);
        check("R1 flags", {62'd0, rsp_sbe, rsp_dbe}, 64'd0);
        rst_n = 1'b1;
        // R1: mask is zero after reset -> armed DMA read is clean
        cfg_write(2'd0, 8'h07); cfg_write(2'd1, 8'h05); cfg_write(2'd2, 8'h05);
        d = 64'h0F1E_2D3C_4B5A_6978;
        do_read(1'b1, d, good_check(d));
        expect_clean("R1 mask zero", d);

        // Table walk: R3 R4 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            vec_t v = VECS[i];
            logic [63:0] exp_corr;
            cfg_write(2'd3, v.mask);
            gc = good_check(v.data);
            do_read(v.dma, v.data, gc);
            check("R10 valid", {63'd0, rsp_valid}, 64'd1);
            check("R3 data", rsp_data, v.data);
            check(v.dma ? "R3 check" : "R4 check", rsp_check,
                  {56'd0, gc ^ (v.dma ? v.mask : 8'h00)});
            check(v.sbe ? "R8 R9 sbe" : "R7 sbe", {63'd0, rsp_sbe}, {63'd0, v.sbe});
            check(v.dbe ? "R9 dbe" : "R7 dbe", {63'd0, rsp_dbe}, {63'd0, v.dbe});
            if (!v.dbe) begin
                exp_corr = (v.flip == 7'd127) ? v.data : (v.data ^ (64'd1 << v.flip));
                check("R8 corr", rsp_corr_data, exp_corr);
            end
        end

        // R10: idle cycle drops valid and flags
        @(negedge clk);
        check("R10 idle valid", {63'd0, rsp_valid}, 64'd0);
        check("R10 idle flags", {62'd0, rsp_sbe, rsp_dbe}, 64'd0);

        // R5: disarm by override key, mask retained
        cfg_write(2'd3, 8'h70);
        cfg_write(2'd1, 8'h04);
        d = 64'h0;
        do_read(1'b1, d, good_check(d));
        expect_clean("R5 okey", d);
        cfg_write(2'd1, 8'h05);
        do_read(1'b1, d, good_check(d));
        check("R5 rearm sbe", {63'd0, rsp_sbe}, 64'd1);
        check("R5 rearm corr", rsp_corr_data, 64'd1 << 62);
        // R2: mode other than 7
        cfg_write(2'd0, 8'h06);
        do_read(1'b1, d, good_check(d));
        expect_clean("R2 mode6", d);
        cfg_write(2'd0, 8'h07);
        // R2: enable key wrong
        cfg_write(2'd2, 8'h0A);
        do_read(1'b1, d, good_check(d));
        expect_clean("R2 ekey", d);
        cfg_write(2'd2, 8'h05);
        // R4: armed CPU read clean, DMA read right after corrupted
        do_read(1'b0, d, good_check(d));
        expect_clean("R4 cpu armed", d);
        do_read(1'b1, d, good_check(d));
        check("R2 armed check", rsp_check, {56'd0, good_check(d) ^ 8'h70});

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule